// File: doc/BRIEF.md
# Processor Status Register with Condition Flags

This block holds the 32-bit status word of a small processor core. The top four bits are the condition flags: negative, zero, carry and overflow. They are derived from the operands, the result and the carry or borrow of the ALU operation that executes in the same cycle. They load only when that operation is marked as flag-setting. Arithmetic operations update all four flags. Logical operations update negative and zero and leave carry and overflow untouched.

The low byte is a control field: two interrupt-mask bits, a state bit and a 5-bit mode. Software reaches the whole word through a write port with a per-bit mask. The control byte accepts such a write only while the privilege input is high. The flag bits accept it at any privilege level. The bits between the flags and the control byte always read as zero.

Top module: `psr_unit`

## Requirements
- R1: After reset the register reads 0x0000_00D3. That is: flags zero, interrupt masks bit 7 and bit 6 set, state bit 5 clear, and mode bits 4:0 = 5'b10011.
- R2: When `flag_we` is high, bit 31 (N) loads bit 31 of `alu_res` on the next clock edge.
- R3: When `flag_we` is high, bit 30 (Z) becomes 1 if `alu_res` is all zeros and 0 otherwise.
- R4: For an add (`op_kind` = 2'b00) with `flag_we` high, bit 29 (C) loads `alu_cy`, which the ALU drives with the carry out of the top bit.
- R5: For a subtract or compare (`op_kind` = 2'b01), `alu_cy` carries the borrow, and bit 29 (C) loads its inverse. So C = 0 when a borrow occurs and C = 1 when none does.
- R6: For an add with `flag_we` high, bit 28 (V) is 1 exactly when both operands share a sign and the result's sign differs from it.
- R7: For a subtract with `flag_we` high, bit 28 (V) is 1 exactly when the operands differ in sign and the result's sign differs from that of `opnd_a`.
- R8: For a logical operation (`op_kind` = 2'b10 or 2'b11) with `flag_we` high, only N and Z update. C and V keep their values.
- R9: With neither `flag_we` nor `sw_we` high, the flags hold. A software write changes each flag bit whose `sw_mask` bit is set, regardless of `priv`.
- R10: A software write changes a bit of 7:0 only if its `sw_mask` bit is set and `priv` is 1. With `priv` at 0 the control byte is unchanged.
- R11: Bits 27:8 always read zero, even after a software write of all ones with all mask bits set.
- R12: When `flag_we` and `sw_we` are both high in one cycle, bits 31:28 take the ALU-derived flags. The control byte still takes the software write if `priv` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 2 | 00 add, 01 subtract/compare, 1x logical |
| opnd_a | input | 32 | First ALU operand |
| opnd_b | input | 32 | Second ALU operand |
| alu_res | input | 32 | ALU result |
| alu_cy | input | 1 | Carry out for add, borrow for subtract |
| flag_we | input | 1 | Current operation sets flags |
| sw_we | input | 1 | Software write strobe |
| sw_data | input | 32 | Software write data |
| sw_mask | input | 32 | Per-bit write enable for the software write |
| priv | input | 1 | Processor is in a privileged mode |
| psr | output | 32 | Status word |

## Verification
The bench targets the carry sense on subtraction. For example, 0 minus 0xFF must leave C clear, and a design that stored the raw borrow would set it. It checks overflow at the signed limits in both directions: 0x7FFFFFFF+1, 0x80000000−1 and 0x7FFFFFFF−(−1). A design that used the add rule for subtraction would miss these or flag opposite-sign adds. It checks that a logical operation after an overflowing add keeps C and V. It checks that an unprivileged write leaves the mode intact. It checks that a collision between flag update and software write resolves in favour of the ALU, which a reversed priority would lose.

// File: rtl/psr_unit.sv
module psr_unit #(
  parameter int XLEN = 32,
  parameter int CTRL_W = 8,
  parameter logic [CTRL_W-1:0] CTRL_RST = 8'hD3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      op_kind,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [XLEN-1:0] alu_res,
  input  logic            alu_cy,
  input  logic            flag_we,
  input  logic            sw_we,
  input  logic [XLEN-1:0] sw_data,
  input  logic [XLEN-1:0] sw_mask,
  input  logic            priv,
  output logic [XLEN-1:0] psr
);

  localparam int FLG_W = 4;
  localparam int RSV_W = XLEN - FLG_W - CTRL_W;
  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_SUB = 2'b01;

  logic [FLG_W-1:0]  flg_q, flg_d;
  logic [CTRL_W-1:0] ctl_q, ctl_d;

  wire is_add   = (op_kind == OP_ADD);
  wire is_sub   = (op_kind == OP_SUB);
  wire is_arith = is_add | is_sub;

  wire sa = opnd_a[XLEN-1];
  wire sb = opnd_b[XLEN-1];
  wire sr = alu_res[XLEN-1];

  wire n_new = sr;
  wire z_new = ~|alu_res;
  wire c_new = is_sub ? ~alu_cy : alu_cy;
  wire v_new = is_sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));

  wire [FLG_W-1:0] alu_flg = is_arith ? {n_new, z_new, c_new, v_new}
                                      : {n_new, z_new, flg_q[1:0]};

  wire [FLG_W-1:0]  fm = sw_mask[XLEN-1 -: FLG_W];
  wire [FLG_W-1:0]  fd = sw_data[XLEN-1 -: FLG_W];
  wire [CTRL_W-1:0] cm = sw_mask[CTRL_W-1:0];
  wire [CTRL_W-1:0] cd = sw_data[CTRL_W-1:0];

  always_comb begin
    flg_d = flg_q;
    if (flag_we)    flg_d = alu_flg;
    else if (sw_we) flg_d = (flg_q & ~fm) | (fd & fm);
  end

  always_comb begin
    ctl_d = ctl_q;
    if (sw_we && priv) ctl_d = (ctl_q & ~cm) | (cd & cm);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q <= '0;
      ctl_q <= CTRL_RST;
    end else begin
      flg_q <= flg_d;
      ctl_q <= ctl_d;
    end
  end

  assign psr = {flg_q, {RSV_W{1'b0}}, ctl_q};

  AST_N_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> psr[XLEN-1] == $past(alu_res[XLEN-1])); // R2
  AST_Z_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> psr[XLEN-2] == ($past(alu_res) == '0)); // R3
  AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_kind == OP_SUB) |=> psr[XLEN-3] == !$past(alu_cy)); // R5
  AST_LOGIC_KEEP_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_kind[1]) |=> psr[XLEN-3 -: 2] == $past(psr[XLEN-3 -: 2])); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_we && !sw_we) |=> $stable(psr[XLEN-1 -: FLG_W])); // R9
  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_we && priv) |=> $stable(psr[CTRL_W-1:0])); // R10

endmodule

// File: tb/psr_unit_tb.sv
module psr_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  op_kind = 0;
  logic [31:0] opnd_a = 0, opnd_b = 0, alu_res = 0;
  logic        alu_cy = 0, flag_we = 0, sw_we = 0, priv = 0;
  logic [31:0] sw_data = 0, sw_mask = 0;
  logic [31:0] psr;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [31:0] exp_psr;

  always #2 clk = ~clk;

  psr_unit u_dut (.clk(clk), .rst_n(rst_n), .op_kind(op_kind), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .alu_res(alu_res), .alu_cy(alu_cy), .flag_we(flag_we),
    .sw_we(sw_we), .sw_data(sw_data), .sw_mask(sw_mask), .priv(priv), .psr(psr));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] ref_flags(logic [1:0] op, logic [31:0] a, logic [31:0] b,
                                           logic [31:0] r, logic [3:0] old);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint s;
    logic c, v;
    if (op == 2'b00) begin
      c = ({1'b0, a} + {1'b0, b}) > 33'hFFFF_FFFF;
      s = sa + sb;
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else if (op == 2'b01) begin
      c = (a >= b);
      s = sa - sb;
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      c = old[1];
      v = old[0];
    end
    return {r[31], (r == 0), c, v};
  endfunction

  task automatic step(logic [1:0] op, logic [31:0] a, logic [31:0] b, logic fwe,
                      logic swe, logic [31:0] d, logic [31:0] m, logic pr);
    logic [31:0] r;
    logic cy;
    logic [3:0] f;
    logic [7:0] c;
    r  = (op == 2'b01) ? a - b : (op == 2'b00) ? a + b : (a & b);
    cy = (op == 2'b01) ? (a < b) : (op == 2'b00) ? (({1'b0, a} + {1'b0, b}) > 33'hFFFF_FFFF) : 1'b0;
    @(negedge clk);
    op_kind = op; opnd_a = a; opnd_b = b; alu_res = r; alu_cy = cy;
    flag_we = fwe; sw_we = swe; sw_data = d; sw_mask = m; priv = pr;
    f = exp_psr[31:28];
    c = exp_psr[7:0];
    if (fwe) f = ref_flags(op, a, b, r, f);
    else if (swe) f = (f & ~m[31:28]) | (d[31:28] & m[31:28]);
    if (swe && pr) c = (c & ~m[7:0]) | (d[7:0] & m[7:0]);
    exp_psr = {f, 20'h0, c};
    @(posedge clk);
    #1;
    flag_we = 0; sw_we = 0;
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    exp_psr = 32'h0000_00D3;
    chk("R1 reset value", psr, 32'h0000_00D3);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_add;
    step(2'b00, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1, 0, 0, 0, 0);
    chk("R4 R6 add carry and overflow", psr, 32'h3000_00D3);
    step(2'b00, 32'h1, 32'h1, 1, 0, 0, 0, 0);
    chk("R2 R4 add no carry", psr, exp_psr);
    step(2'b00, 32'h7FFF_FFFF, 32'h1, 1, 0, 0, 0, 0);
    chk("R6 add positive overflow", psr, 32'h9000_00D3);
    step(2'b00, 32'hFFFF_FFFF, 32'h1, 1, 0, 0, 0, 0);
    chk("R3 add zero with carry", psr, 32'h6000_00D3);
    step(2'b00, 32'h8000_0000, 32'h7FFF_FFFF, 1, 0, 0, 0, 0);
    chk("R6 mixed signs never overflow", psr, 32'h8000_00D3);
  endtask

  task automatic t_sub;
    step(2'b01, 32'h0, 32'hFF, 1, 0, 0, 0, 0);
    chk("R5 borrow clears carry", psr, 32'h8000_00D3);
    step(2'b01, 32'h5, 32'h5, 1, 0, 0, 0, 0);
    chk("R5 R3 equal compare", psr, 32'h6000_00D3);
    step(2'b01, 32'h8000_0000, 32'h1, 1, 0, 0, 0, 0);
    chk("R7 sub negative overflow", psr, 32'h3000_00D3);
    step(2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 0, 0);
    chk("R7 sub positive overflow", psr, 32'h9000_00D3);
  endtask

  task automatic t_logic;
    step(2'b00, 32'h8000_0000, 32'h8000_0000, 1, 0, 0, 0, 0);
    chk("R8 setup C V", psr, 32'h7000_00D3);
    step(2'b10, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1, 0, 0, 0, 0);
    chk("R8 logic keeps C V", psr, 32'h7000_00D3);
    step(2'b11, 32'h8000_0001, 32'hFFFF_FFFF, 1, 0, 0, 0, 0);
    chk("R8 logic negative", psr, 32'hB000_00D3);
  endtask

  task automatic t_hold_sw;
    step(2'b01, 32'h0, 32'h1, 0, 0, 0, 0, 1);
    chk("R9 hold without strobe", psr, 32'hB000_00D3);
    step(2'b00, 0, 0, 0, 1, 32'h5000_0000, 32'hC000_0000, 0);
    chk("R9 masked flag write unprivileged", psr, 32'h7000_00D3);
  endtask

  task automatic t_ctrl;
    step(2'b00, 0, 0, 0, 1, 32'h0000_0010, 32'h0000_00FF, 0);
    chk("R10 unprivileged write ignored", psr, 32'h7000_00D3);
    step(2'b00, 0, 0, 0, 1, 32'h0000_0010, 32'h0000_00FF, 1);
    chk("R10 privileged write", psr, 32'h7000_0010);
    step(2'b00, 0, 0, 0, 1, 32'h0000_00FF, 32'h0000_0080, 1);
    chk("R10 masked privileged write", psr, 32'h7000_0090);
  endtask

  task automatic t_reserved;
    step(2'b00, 0, 0, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    chk("R11 reserved read zero", psr, 32'hF000_00FF);
  endtask

  task automatic t_collide;
    step(2'b00, 32'h1, 32'h1, 1, 1, 32'hF000_0013, 32'hFFFF_FFFF, 1);
    chk("R12 flags win collision", psr, 32'h0000_0013);
  endtask

  initial begin
    t_reset;
    t_add;
    t_sub;
    t_logic;
    t_hold_sw;
    t_ctrl;
    t_reserved;
    t_collide;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule